// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block is the main 16-bit control and status word of a ring-buffer Ethernet controller. It sits on a simple host register bus with an address, a write strobe, write data and read data. The receive and transmit engines report events to it as one-cycle pulses. It latches those events as sticky flags that software clears by writing ones. It also forms two summary bits, one for errors and one for interrupt sources, and raises an interrupt line when the interrupt-enable bit is set.

Software drives the controller through set-only command bits: initialise, start, stop and transmit demand. A small run-state machine turns these commands into held or pulsed outputs for the engines. The machine has four states. ST_HALTED is entered at reset and on any stop write. ST_LOADING is entered from any state other than ST_LOADING when initialise is written, and is left when the initialisation-done event arrives. From there the machine goes to ST_ACTIVE if start is already set, and to ST_READY if it is not. A start write moves ST_HALTED or ST_READY to ST_ACTIVE. A stop write takes every state back to ST_HALTED. Stop has priority over every other command.

Bit map, from bit 15 down to bit 0: ERR, BABL (babble), CERR (collision test error), MISS, MERR (memory error), RINT, TINT, IDON (init done), INTR, INEA, RXON, TXON, TDMD, STOP, STRT, INIT.

Top module: `nic_csr`

## Requirements
- R1: After reset the register reads 0x0004, with only STOP set. The irq output is 0, and cmd_init, cmd_start, cmd_tx_demand and cmd_stop are all 0.
- R2: Event flags occupy bits 14..8 in this order: BABL, CERR, MISS, MERR, RINT, TINT, IDON. The matching evt_in bit (evt_in[6] is BABL, evt_in[0] is IDON) sets each flag. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R3: An event pulse in the same cycle as a clear of that flag leaves the flag set. The clear can come from a write-one or from a stop write.
- R4: ERR (bit 15) reads as the OR of BABL, CERR, MISS and MERR. INTR (bit 7) reads as the OR of BABL, MISS, MERR, RINT, TINT and IDON. CERR alone does not set INTR.
- R5: INEA (bit 6) is read-write. The irq output is 1 exactly when INEA and INTR are both 1.
- R6: INIT (bit 0), STRT (bit 1) and TDMD (bit 3) are set by writing 1. Writing 0 to them has no effect.
- R7: RXON (bit 5) and TXON (bit 4) ignore writes. Each reads 1 only in ST_ACTIVE while its ring-disable input (rx_ring_off or tx_ring_off) is 0.
- R8: A write with bit 2 set moves to ST_HALTED and sets STOP. The same write clears STRT, INIT, TDMD, RXON, TXON and all event flags, and pulses cmd_stop for one cycle. STOP wins over INIT or STRT written together with it. INEA is kept.
- R9: Writing INIT without STOP clears STOP and enters ST_LOADING, where cmd_init is 1. The IDON event then leaves ST_LOADING, going to ST_ACTIVE if STRT is set and to ST_READY if it is not.
- R10: Writing STRT without INIT or STOP in ST_HALTED or ST_READY enters ST_ACTIVE, where cmd_start is 1.
- R11: TDMD drives cmd_tx_demand. A tx_ack pulse clears it. A TDMD write is ignored in ST_HALTED.
- R12: A write whose bus_addr differs from CSR_ADDR changes nothing, and reads at such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not addressed |
| evt_in | input | 7 | Event pulses, bit 6 BABL down to bit 0 IDON |
| tx_ack | input | 1 | Transmit engine accepted the demand |
| rx_ring_off | input | 1 | Receive ring access disabled |
| tx_ring_off | input | 1 | Transmit ring access disabled |
| irq | output | 1 | Interrupt request |
| cmd_init | output | 1 | Initialise command, held in ST_LOADING |
| cmd_start | output | 1 | Run command, held in ST_ACTIVE |
| cmd_stop | output | 1 | One-cycle stop pulse |
| cmd_tx_demand | output | 1 | Transmit demand, held until acknowledged |

## Verification
Two functions can fall in the same cycle here. A hardware event pulse can set a flag while a host write clears that same flag, either by writing a one to it or through a stop write. The bench provokes both cases by raising the write strobe and the event pulse on the same falling edge. It then judges the result from the read word on the next cycle: the flag, ERR, INTR and irq must all show the event as kept.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
    localparam int CSR_W = 16;
    localparam int EVT_N = 7;

    localparam int B_ERR    = 15;
    localparam int B_EVT_LO = 8;
    localparam int B_EVT_HI = B_EVT_LO + EVT_N - 1;
    localparam int B_INTR   = 7;
    localparam int B_INEA   = 6;
    localparam int B_RXON   = 5;
    localparam int B_TXON   = 4;
    localparam int B_TDMD   = 3;
    localparam int B_STOP   = 2;
    localparam int B_STRT   = 1;
    localparam int B_INIT   = 0;

    // event index inside the flag vector (bit 6 babble ... bit 0 init done)
    localparam int EV_IDON = 0;

    // flags feeding the error summary: babble, collision test, missed, memory
    localparam logic [EVT_N-1:0] ERR_SRC  = 7'b111_1000;
    // flags feeding the interrupt summary: all but the collision test error
    localparam logic [EVT_N-1:0] INTR_SRC = 7'b101_1111;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_LOADING = 2'd1,
        ST_READY   = 2'd2,
        ST_ACTIVE  = 2'd3
    } run_state_e;
endpackage

// File: rtl/nic_csr_events.sv
module nic_csr_events
    import nic_csr_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_in,
    input  logic [N-1:0] clr_mask,
    input  logic         stop_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (evt_in[i]) begin
                flags[i] <= 1'b1;          // event beats any clear
            end else if (stop_clr || clr_mask[i]) begin
                flags[i] <= 1'b0;
            end
        end

        assert_evt_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt_in[i] |=> flags[i]);

        assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !evt_in[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/nic_csr_fsm.sv
module nic_csr_fsm
    import nic_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sel,
    input  logic [3:0] cmd_bits,
    input  logic       idon_evt,
    input  logic       tx_ack,
    input  logic       rx_ring_off,
    input  logic       tx_ring_off,
    output logic       halted,
    output logic       init_q,
    output logic       strt_q,
    output logic       tdmd_q,
    output logic       rxon_q,
    output logic       txon_q,
    output logic       stop_pulse,
    output logic       cmd_init,
    output logic       cmd_start
);
    run_state_e state_q, state_d;

    logic stop_w, init_w, strt_w, tdmd_w;
    assign stop_w = wr_sel && cmd_bits[B_STOP];
    assign init_w = wr_sel && cmd_bits[B_INIT];
    assign strt_w = wr_sel && cmd_bits[B_STRT];
    assign tdmd_w = wr_sel && cmd_bits[B_TDMD];

    always_comb begin
        state_d = state_q;
        if (stop_w) begin
            state_d = ST_HALTED;
        end else begin
            unique case (state_q)
                ST_HALTED, ST_READY, ST_ACTIVE: begin
                    if (init_w)      state_d = ST_LOADING;
                    else if (strt_w) state_d = ST_ACTIVE;
                end
                ST_LOADING: begin
                    if (idon_evt) state_d = (strt_q || strt_w) ? ST_ACTIVE : ST_READY;
                end
                default: state_d = ST_HALTED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q     <= 1'b0;
            strt_q     <= 1'b0;
            tdmd_q     <= 1'b0;
            rxon_q     <= 1'b0;
            txon_q     <= 1'b0;
            stop_pulse <= 1'b0;
        end else if (stop_w) begin
            init_q     <= 1'b0;
            strt_q     <= 1'b0;
            tdmd_q     <= 1'b0;
            rxon_q     <= 1'b0;
            txon_q     <= 1'b0;
            stop_pulse <= 1'b1;
        end else begin
            init_q     <= init_q || init_w;
            strt_q     <= strt_q || strt_w;
            if (tdmd_w && state_d != ST_HALTED) tdmd_q <= 1'b1;
            else if (tx_ack)                    tdmd_q <= 1'b0;
            rxon_q     <= (state_d == ST_ACTIVE) && !rx_ring_off;
            txon_q     <= (state_d == ST_ACTIVE) && !tx_ring_off;
            stop_pulse <= 1'b0;
        end
    end

    assign halted    = (state_q == ST_HALTED);
    assign cmd_init  = (state_q == ST_LOADING);
    assign cmd_start = (state_q == ST_ACTIVE);

    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (state_q == ST_HALTED && !strt_q && !init_q && !tdmd_q
                    && !rxon_q && !txon_q && stop_pulse));

    assert_run_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rxon_q || txon_q) |-> (state_q == ST_ACTIVE));

    assert_tdmd_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && !tdmd_w) |=> !tdmd_q);

    assert_halt_no_demand_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED) |-> !tdmd_q);

    assert_loading_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOADING && idon_evt && !stop_w) |=> (state_q != ST_LOADING));
endmodule

// File: rtl/nic_csr_summary.sv
module nic_csr_summary
    import nic_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inea_wr,
    input  logic             inea_val,
    input  logic [EVT_N-1:0] flags,
    input  logic             rxon,
    input  logic             txon,
    input  logic             tdmd,
    input  logic             halted,
    input  logic             strt,
    input  logic             init,
    output logic [CSR_W-1:0] word,
    output logic             irq
);
    logic inea_q;
    logic err_sum, intr_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       inea_q <= 1'b0;
        else if (inea_wr) inea_q <= inea_val;
    end

    assign err_sum  = |(flags & ERR_SRC);
    assign intr_sum = |(flags & INTR_SRC);
    assign irq      = inea_q && intr_sum;

    always_comb begin
        word                     = '0;
        word[B_ERR]              = err_sum;
        word[B_EVT_HI:B_EVT_LO]  = flags;
        word[B_INTR]             = intr_sum;
        word[B_INEA]             = inea_q;
        word[B_RXON]             = rxon;
        word[B_TXON]             = txon;
        word[B_TDMD]             = tdmd;
        word[B_STOP]             = halted;
        word[B_STRT]             = strt;
        word[B_INIT]             = init;
    end

    assert_inea_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !inea_wr |=> $stable(inea_q));
endmodule

// File: rtl/nic_csr.sv
module nic_csr
    import nic_csr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CSR_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic [EVT_N-1:0]  evt_in,
    input  logic              tx_ack,
    input  logic              rx_ring_off,
    input  logic              tx_ring_off,
    output logic              irq,
    output logic              cmd_init,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_tx_demand
);
    logic             sel, wr_sel;
    logic [EVT_N-1:0] clr_mask, flags;
    logic             halted, init_q, strt_q, tdmd_q, rxon_q, txon_q;
    logic [CSR_W-1:0] word;
    logic             unused_wbits;

    assign sel      = (bus_addr == CSR_ADDR);
    assign wr_sel   = bus_wr && sel;
    assign clr_mask = wr_sel ? bus_wdata[B_EVT_HI:B_EVT_LO] : '0;
    assign unused_wbits = ^{bus_wdata[B_ERR], bus_wdata[B_INTR],
                            bus_wdata[B_RXON], bus_wdata[B_TXON]};

    nic_csr_events #(.N(EVT_N)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .clr_mask (clr_mask),
        .stop_clr (wr_sel && bus_wdata[B_STOP]),
        .flags    (flags)
    );

    nic_csr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel      (wr_sel),
        .cmd_bits    (bus_wdata[B_TDMD:B_INIT]),
        .idon_evt    (evt_in[EV_IDON]),
        .tx_ack      (tx_ack),
        .rx_ring_off (rx_ring_off),
        .tx_ring_off (tx_ring_off),
        .halted      (halted),
        .init_q      (init_q),
        .strt_q      (strt_q),
        .tdmd_q      (tdmd_q),
        .rxon_q      (rxon_q),
        .txon_q      (txon_q),
        .stop_pulse  (cmd_stop),
        .cmd_init    (cmd_init),
        .cmd_start   (cmd_start)
    );

    nic_csr_summary u_summary (
        .clk      (clk),
        .rst_n    (rst_n),
        .inea_wr  (wr_sel),
        .inea_val (bus_wdata[B_INEA]),
        .flags    (flags),
        .rxon     (rxon_q),
        .txon     (txon_q),
        .tdmd     (tdmd_q),
        .halted   (halted),
        .strt     (strt_q),
        .init     (init_q),
        .word     (word),
        .irq      (irq)
    );

    assign bus_rdata     = sel ? word : '0;
    assign cmd_tx_demand = tdmd_q;

    assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags));

    assert_stop_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |-> word[B_STOP]);

    assert_foreign_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel && evt_in == '0 && !tx_ack) |=> $stable(word));
endmodule

// File: tb/nic_csr_tb.sv
module nic_csr_tb;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] MY_ADDR = 4'h0;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr;
    logic [15:0]       bus_wdata, bus_rdata;
    logic [6:0]        evt_in;
    logic              tx_ack, rx_ring_off, tx_ring_off;
    logic              irq, cmd_init, cmd_start, cmd_stop, cmd_tx_demand;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    nic_csr #(.ADDR_W(ADDR_W), .CSR_ADDR(MY_ADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .tx_ack(tx_ack), .rx_ring_off(rx_ring_off), .tx_ring_off(tx_ring_off),
        .irq(irq), .cmd_init(cmd_init), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_tx_demand(cmd_tx_demand)
    );

    // monitor: compare {rdata, irq, cmd_init, cmd_start, cmd_tx_demand}
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [19:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {bus_rdata, irq, cmd_init, cmd_start, cmd_tx_demand};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: actual csr=%h irq/init/start/txd=%b expected csr=%h irq/init/start/txd=%b",
                         t, a[19:4], a[3:0], e[19:4], e[3:0]);
            end
        end
    end

    task automatic expect_state(input logic [15:0] c, input logic i, input logic ci,
                                input logic cs, input logic ct, input string tag);
        exp_q.push_back({c, i, ci, cs, ct});
        tag_q.push_back(tag);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic direct_check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [15:0] d, input logic [6:0] e, input logic a);
        @(negedge clk);
        bus_wr = w; bus_wdata = d; evt_in = e; tx_ack = a;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_in = '0; tx_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = MY_ADDR; bus_wr = 1'b0; bus_wdata = '0;
        evt_in = '0; tx_ack = 1'b0; rx_ring_off = 1'b0; tx_ring_off = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        direct_check({15'd0, cmd_stop}, 16'd0, "R1 cmd_stop");
        expect_state(16'h0004, 0, 0, 0, 0, "R1 reset");

        drive(1, 16'h0001, 0, 0);
        expect_state(16'h0001, 0, 1, 0, 0, "R9 init write");
        drive(1, 16'h0000, 0, 0);
        expect_state(16'h0001, 0, 1, 0, 0, "R6 zero write keeps INIT");
        drive(0, 0, 7'h01, 0);
        expect_state(16'h0181, 0, 0, 0, 0, "R9 idon to ready / R4 intr");
        drive(1, 16'h0040, 0, 0);
        expect_state(16'h01C1, 1, 0, 0, 0, "R5 inea irq");
        drive(1, 16'h0140, 0, 0);
        expect_state(16'h0041, 0, 0, 0, 0, "R2 clear idon");
        drive(1, 16'h0042, 0, 0);
        expect_state(16'h0073, 0, 0, 1, 0, "R10 start");
        drive(1, 16'h0070, 0, 0);
        expect_state(16'h0073, 0, 0, 1, 0, "R7 rxon txon write ignored");
        drive(0, 0, 7'h20, 0);
        expect_state(16'hA073, 0, 0, 1, 0, "R4 cerr sets err only");
        drive(0, 0, 7'h10, 0);
        expect_state(16'hB0F3, 1, 0, 1, 0, "R4 miss sets intr");
        drive(1, 16'h3040, 0, 0);
        expect_state(16'h0073, 0, 0, 1, 0, "R2 clear cerr miss");
        drive(1, 16'h0440, 7'h04, 0);
        expect_state(16'h04F3, 1, 0, 1, 0, "R3 event beats clear");
        drive(1, 16'h0440, 0, 0);
        expect_state(16'h0073, 0, 0, 1, 0, "R2 clear rint");
        drive(1, 16'h0048, 0, 0);
        expect_state(16'h007B, 0, 0, 1, 1, "R11 tdmd set");
        drive(1, 16'h0040, 0, 0);
        expect_state(16'h007B, 0, 0, 1, 1, "R6 zero keeps tdmd");
        drive(0, 0, 0, 1);
        expect_state(16'h0073, 0, 0, 1, 0, "R11 ack clears tdmd");

        bus_addr = 4'h5;
        drive(1, 16'h0004, 0, 0);
        direct_check(bus_rdata, 16'h0000, "R12 foreign read");
        bus_addr = MY_ADDR;
        @(negedge clk);
        expect_state(16'h0073, 0, 0, 1, 0, "R12 foreign write ignored");

        rx_ring_off = 1'b1;
        @(negedge clk);
        expect_state(16'h0053, 0, 0, 1, 0, "R7 rx ring off");
        rx_ring_off = 1'b0;
        @(negedge clk);
        expect_state(16'h0073, 0, 0, 1, 0, "R7 rx ring on");

        drive(0, 0, 7'h40, 0);
        drive(1, 16'h0048, 0, 0);
        expect_state(16'hC0FB, 1, 0, 1, 1, "R4 babble");
        drive(1, 16'h0046, 0, 0);
        direct_check({15'd0, cmd_stop}, 16'd1, "R8 stop pulse");
        expect_state(16'h0044, 0, 0, 0, 0, "R8 stop wins and clears");
        direct_check({15'd0, cmd_stop}, 16'd0, "R8 stop pulse one cycle");
        drive(1, 16'h0048, 0, 0);
        expect_state(16'h0044, 0, 0, 0, 0, "R11 tdmd ignored halted");
        drive(1, 16'h0043, 0, 0);
        expect_state(16'h0043, 0, 1, 0, 0, "R9 init with start");
        drive(0, 0, 7'h01, 0);
        expect_state(16'h01F3, 1, 0, 1, 0, "R9 idon to active");
        drive(1, 16'h0044, 7'h08, 0);
        expect_state(16'h88C4, 1, 0, 0, 0, "R3 event beats stop clear");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule